// File: doc/BRIEF.md
# PLL-Derived System Clock Ratio Divider

This block turns one fast source clock into three phase-aligned clock-enable streams for a chip's clock tree: a core enable, a bus enable, and a peripheral enable that is cascaded from the bus enable rather than taken straight from the source. Each stream is a single-cycle pulse repeated once every N counted source ticks. The three ratios come from encoded fields of a 32-bit configuration word. That word is captured on a load strobe, and the block reports the decoded divisors so that the resulting frequencies can be cross-checked.

The block runs on the system clock. The source is qualified by one of two tick inputs. `pllTick` marks cycles in which the PLL output advances. `refTick` marks cycles in which the reference oscillator advances and is used when the PLL is bypassed. One configuration bit chooses between them. The bus ratio table includes the non-power-of-two divisors 5 and 6, and those enables are spaced evenly from period to period.

Top module: `clk_ratio_div`

## Requirements
- R1: The core ratio comes from cfgWord[27:25]. Codes 0, 1, 2, 3 and 4 give divisors 1, 2, 4, 8 and 16. Codes 5, 6 and 7 give divisor 1.
- R2: The bus ratio comes from cfgWord[22:20]. Codes 0 to 7 give divisors 1, 2, 4, 5, 6, 8, 16 and 32, in that order.
- R3: The peripheral ratio comes from cfgWord[19:18]. Codes 0 to 3 give divisors 1, 2, 4 and 8, and they count bus enables, not source ticks.
- R4: When cfgWord[23] is 1, the counted source is `pllTick`. When it is 0, the PLL is bypassed and `refTick` is counted instead. Without a counted tick, no enable is issued.
- R5: Each enable is a one-cycle pulse issued once every N counted ticks, with identical spacing between all successive pulses, including for bus divisors 5 and 6.
- R6: `periEn` is only ever high in a cycle where `busEn` is also high.
- R7: `cfgLoad` captures the word and restarts all three counters together. A tick in the load cycle is not counted, no enable is high in the cycle after the load, and the first counted tick afterwards fires all three enables in the same cycle.
- R8: `coreDiv`, `busDiv` and `periDiv` report the decoded divisors of the captured word from the cycle after the load onward, and otherwise hold. Bits outside 27:18 have no effect.
- R9: Reset clears the captured word to zero: reference source, all divisors 1, and no enable while reset is held.
- R10: The enables are registered: a counted tick seen at a clock edge with its counter at zero shows up as a pulse during the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 32 | Configuration word with the ratio and source fields |
| cfgLoad | input | 1 | Capture cfgWord and restart all counters |
| pllTick | input | 1 | PLL source advance qualifier |
| refTick | input | 1 | Reference source advance qualifier (bypass) |
| coreEn | output | 1 | Core clock enable pulse |
| busEn | output | 1 | Bus clock enable pulse |
| periEn | output | 1 | Peripheral clock enable pulse |
| coreDiv | output | 6 | Decoded core divisor |
| busDiv | output | 6 | Decoded bus divisor |
| periDiv | output | 6 | Decoded peripheral divisor |
| pllSel | output | 1 | 1 when the PLL tick is the counted source |

## Verification
A table of configuration words covers every core code, including the three aliases of divisor 1, and every bus and peripheral code. Each word runs over a window that is a multiple of every period, so pulse counts, gap uniformity and the alignment of the first pulses separate a mis-decoded code, a counter off by one, and a peripheral counter fed from the wrong stream. Two of the words run in bypass with a reference tick on every other cycle, which doubles each period and exposes a wrong source selection. Directed runs then stall the PLL tick to show that no pulse appears without a tick, and reload in mid-period to show that the restart realigns the phase.

// File: rtl/clkrat_pkg.sv
`timescale 1ns/1ps
package clkrat_pkg;

  // Field positions that the decoders depend on
  localparam int CORE_LSB   = 25;
  localparam int CORE_CW    = 3;
  localparam int PLL_ON_BIT = 23;
  localparam int BUS_LSB    = 20;
  localparam int BUS_CW     = 3;
  localparam int PERI_LSB   = 18;
  localparam int PERI_CW    = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic srcTick;
  } divStrobe_t;

  function automatic int unsigned decodeCore(input logic [CORE_CW-1:0] code);
    // codes beyond 4 alias to divide-by-one
    if (code > 3'd4) return 1;
    return 1 << code;
  endfunction

  function automatic int unsigned decodeBus(input logic [BUS_CW-1:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 5;
      3'd4: return 6;
      3'd5: return 8;
      3'd6: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic int unsigned decodePeri(input logic [PERI_CW-1:0] code);
    return 1 << code;
  endfunction

endpackage

// File: rtl/clkrat_ctrl.sv
`timescale 1ns/1ps
module clkrat_ctrl
  import clkrat_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             cfgLoad,
  input  logic             pllTick,
  input  logic             refTick,
  output divStrobe_t       strobe,
  output logic [DIV_W-1:0] coreDiv,
  output logic [DIV_W-1:0] busDiv,
  output logic [DIV_W-1:0] periDiv,
  output logic             pllSel
);

  logic [CORE_CW-1:0] coreCode;
  logic [BUS_CW-1:0]  busCode;
  logic [PERI_CW-1:0] periCode;
  logic               pllOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreCode <= '0;
      busCode  <= '0;
      periCode <= '0;
      pllOn    <= 1'b0;
    end else if (cfgLoad) begin
      coreCode <= cfgWord[CORE_LSB +: CORE_CW];
      busCode  <= cfgWord[BUS_LSB +: BUS_CW];
      periCode <= cfgWord[PERI_LSB +: PERI_CW];
      pllOn    <= cfgWord[PLL_ON_BIT];
    end
  end

  always_comb begin
    coreDiv        = DIV_W'(decodeCore(coreCode));
    busDiv         = DIV_W'(decodeBus(busCode));
    periDiv        = DIV_W'(decodePeri(periCode));
    pllSel         = pllOn;
    strobe.restart = cfgLoad;
    strobe.srcTick = pllOn ? pllTick : refTick;
  end

  AST_SRC_CAPTURED: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> pllSel == $past(cfgWord[PLL_ON_BIT])); // R4

  AST_RATIOS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(coreDiv) && $stable(busDiv) && $stable(periDiv)); // R8

endmodule

// File: rtl/clkrat_counter.sv
`timescale 1ns/1ps
module clkrat_counter #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             advance,
  input  logic [DIV_W-1:0] div,
  output logic             fire
);

  logic [DIV_W-1:0] cnt;
  logic             atWrap;

  assign atWrap = (cnt == div - DIV_W'(1));
  assign fire   = advance && !restart && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN || restart) cnt <= '0;
    else if (advance)     cnt <= atWrap ? '0 : cnt + DIV_W'(1);
  end

  AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rstN)
    cnt < div); // R5

endmodule

// File: rtl/clkrat_datapath.sv
`timescale 1ns/1ps
module clkrat_datapath
  import clkrat_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic [DIV_W-1:0] coreDiv,
  input  logic [DIV_W-1:0] busDiv,
  input  logic [DIV_W-1:0] periDiv,
  output logic             coreEn,
  output logic             busEn,
  output logic             periEn
);

  logic coreFire, busFire, periFire;

  clkrat_counter #(.DIV_W(DIV_W)) u_coreCnt (
    .clk(clk), .rstN(rstN), .restart(strobe.restart),
    .advance(strobe.srcTick), .div(coreDiv), .fire(coreFire));

  clkrat_counter #(.DIV_W(DIV_W)) u_busCnt (
    .clk(clk), .rstN(rstN), .restart(strobe.restart),
    .advance(strobe.srcTick), .div(busDiv), .fire(busFire));

  // peripheral counter steps on bus enables only
  clkrat_counter #(.DIV_W(DIV_W)) u_periCnt (
    .clk(clk), .rstN(rstN), .restart(strobe.restart),
    .advance(busFire), .div(periDiv), .fire(periFire));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreEn <= 1'b0;
      busEn  <= 1'b0;
      periEn <= 1'b0;
    end else begin
      coreEn <= coreFire;
      busEn  <= busFire;
      periEn <= periFire;
    end
  end

  AST_PERI_WITH_BUS: assert property (@(posedge clk) disable iff (!rstN)
    periEn |-> busEn); // R6

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> !coreEn && !busEn && !periEn); // R7

  AST_NO_TICK_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.srcTick |=> !coreEn && !busEn); // R4

  AST_CORE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (coreEn && coreDiv > DIV_W'(1)) |=> !coreEn); // R5

  AST_BUS_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && busDiv > DIV_W'(1)) |=> !busEn); // R5

endmodule

// File: rtl/clk_ratio_div.sv
`timescale 1ns/1ps
module clk_ratio_div
  import clkrat_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             cfgLoad,
  input  logic             pllTick,
  input  logic             refTick,
  output logic             coreEn,
  output logic             busEn,
  output logic             periEn,
  output logic [DIV_W-1:0] coreDiv,
  output logic [DIV_W-1:0] busDiv,
  output logic [DIV_W-1:0] periDiv,
  output logic             pllSel
);

  divStrobe_t strobe;

  clkrat_ctrl #(.CFG_W(CFG_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .cfgLoad(cfgLoad),
    .pllTick(pllTick), .refTick(refTick), .strobe(strobe),
    .coreDiv(coreDiv), .busDiv(busDiv), .periDiv(periDiv), .pllSel(pllSel));

  clkrat_datapath #(.DIV_W(DIV_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .coreDiv(coreDiv), .busDiv(busDiv), .periDiv(periDiv),
    .coreEn(coreEn), .busEn(busEn), .periEn(periEn));

endmodule

// File: tb/test_clk_ratio_div.sv
`timescale 1ns/1ps
module test_clk_ratio_div;

  localparam int WIN = 7680;
  localparam int NV  = 10;
  // codes per vector: core, bus, peri, pll-on; expected divisors
  localparam int V_CORE[NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 4, 1};
  localparam int V_BUS [NV] = '{0, 1, 3, 4, 5, 6, 7, 2, 3, 4};
  localparam int V_PERI[NV] = '{0, 1, 2, 3, 0, 1, 3, 0, 1, 2};
  localparam int V_PLL [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 0};
  localparam int E_CORE[NV] = '{1, 2, 4, 8, 16, 1, 1, 1, 16, 2};
  localparam int E_BUS [NV] = '{1, 2, 5, 6, 8, 16, 32, 4, 5, 6};
  localparam int E_PERI[NV] = '{1, 2, 4, 8, 1, 2, 8, 1, 2, 4};

  logic        clk = 1'b0;
  logic        rstN, cfgLoad, pllTick, refTick;
  logic [31:0] cfgWord;
  logic        coreEn, busEn, periEn, pllSel;
  logic [5:0]  coreDiv, busDiv, periDiv;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  clk_ratio_div i_clk_ratio_div (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .cfgLoad(cfgLoad),
    .pllTick(pllTick), .refTick(refTick),
    .coreEn(coreEn), .busEn(busEn), .periEn(periEn),
    .coreDiv(coreDiv), .busDiv(busDiv), .periDiv(periDiv), .pllSel(pllSel));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference tick: high on every other cycle
  initial begin
    refTick = 1'b0;
    forever @(negedge clk) refTick = ~refTick;
  end

  function automatic logic [31:0] mkCfg(input int c, input int b, input int p, input int s);
    logic [31:0] w;
    w = 32'h1100_5A5A; // bits outside 27:18 (R8)
    w[27:25] = 3'(c);
    w[22:20] = 3'(b);
    w[19:18] = 2'(p);
    w[23]    = 1'(s);
    return w;
  endfunction

  // drive a load; returns at the negedge after the load edge
  task automatic loadCfg(input logic [31:0] w);
    @(negedge clk);
    cfgWord = w;
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic runWindow(input int pc, input int pb, input int pp, input string tag);
    int nC = 0, nB = 0, nP = 0;
    int lC = -1, lB = -1, lP = -1;
    bit gapC = 1'b1, gapB = 1'b1, gapP = 1'b1;
    bit firstSeen = 1'b0, aligned = 1'b1, periOk = 1'b1;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (periEn && !busEn) periOk = 1'b0;
      if (coreEn && !firstSeen) begin
        firstSeen = 1'b1;
        if (!(busEn && periEn)) aligned = 1'b0;
      end
      if (coreEn) begin if (lC >= 0 && i - lC != pc) gapC = 1'b0; lC = i; nC++; end
      if (busEn)  begin if (lB >= 0 && i - lB != pb) gapB = 1'b0; lB = i; nB++; end
      if (periEn) begin if (lP >= 0 && i - lP != pp) gapP = 1'b0; lP = i; nP++; end
    end
    chk(nC == WIN / pc, "R1", {tag, " core pulse count"}, nC, WIN / pc);
    chk(nB == WIN / pb, "R2", {tag, " bus pulse count"}, nB, WIN / pb);
    chk(nP == WIN / pp, "R3", {tag, " peri pulse count"}, nP, WIN / pp);
    chk(gapC && gapB && gapP, "R5", {tag, " uniform spacing"},
        int'({gapC, gapB, gapP}), 7);
    chk(aligned, "R7", {tag, " first pulses aligned"}, int'(aligned), 1);
    chk(periOk, "R6", {tag, " peri only with bus"}, int'(periOk), 1);
  endtask

  initial begin
    #1900000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit quiet;
    rstN = 1'b0; cfgLoad = 1'b0; cfgWord = '0; pllTick = 1'b1;

    // R9: no enable while reset is held
    quiet = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (coreEn || busEn || periEn) quiet = 1'b0;
    end
    chk(quiet, "R9", "no enable in reset", int'(quiet), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(coreDiv == 1 && busDiv == 1 && periDiv == 1, "R9", "reset divisors",
        int'({coreDiv, busDiv, periDiv}), int'({6'd1, 6'd1, 6'd1}));
    chk(pllSel == 1'b0, "R9", "reset source is reference", int'(pllSel), 0);
    // R4: reference source in bypass, one pulse per two cycles
    n = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); if (coreEn) n++; end
    chk(n == 8, "R4", "bypass pulse count after reset", n, 8);

    // main table
    for (int v = 0; v < NV; v++) begin
      int k;
      k = (V_PLL[v] != 0) ? 1 : 2;
      loadCfg(mkCfg(V_CORE[v], V_BUS[v], V_PERI[v], V_PLL[v]));
      chk(!coreEn && !busEn && !periEn, "R7", $sformatf("v%0d quiet after load", v),
          int'({coreEn, busEn, periEn}), 0);
      chk(coreDiv == E_CORE[v] && busDiv == E_BUS[v] && periDiv == E_PERI[v], "R8",
          $sformatf("v%0d reported divisors", v),
          int'({coreDiv, busDiv, periDiv}),
          int'({6'(E_CORE[v]), 6'(E_BUS[v]), 6'(E_PERI[v])}));
      chk(pllSel == 1'(V_PLL[v]), "R4", $sformatf("v%0d source select", v),
          int'(pllSel), V_PLL[v]);
      runWindow(k * E_CORE[v], k * E_BUS[v], k * E_BUS[v] * E_PERI[v],
                $sformatf("v%0d", v));
    end

    // R4: stalled PLL tick gives no pulse
    loadCfg(mkCfg(0, 0, 0, 1));
    pllTick = 1'b0;
    quiet = 1'b1;
    repeat (20) begin @(negedge clk); if (coreEn || busEn || periEn) quiet = 1'b0; end
    chk(quiet, "R4", "no pulse without pll tick", int'(quiet), 1);
    pllTick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(coreEn && busEn && periEn, "R10", "pulse one cycle after tick resumes",
        int'({coreEn, busEn, periEn}), 7);

    // R7: reload mid-period realigns the phase
    loadCfg(mkCfg(3, 5, 1, 1)); // core 8, bus 8, peri 2
    repeat (4) @(negedge clk);
    loadCfg(mkCfg(3, 5, 1, 1));
    @(negedge clk);
    chk(coreEn && busEn && periEn, "R7", "reload restarts all counters",
        int'({coreEn, busEn, periEn}), 7);
    n = 0;
    for (int i = 0; i < 7; i++) begin @(negedge clk); if (coreEn || busEn) n++; end
    chk(n == 0, "R5", "gap after realigned pulse", n, 0);
    @(negedge clk);
    chk(coreEn && busEn && !periEn, "R3", "second bus pulse without peri",
        int'({coreEn, busEn, periEn}), 6);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule